// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block sits between a processor port and a slower main memory that is addressed by word. Addresses, data and memory words are all 16 bits wide. The cache holds 128 lines of 16 words each. Each line has one valid bit and a 5-bit tag. The address of a memory block chooses exactly one line.

A read that hits is answered from the line store without any memory traffic. A read that misses loads the whole line from memory, one word per request/acknowledge handshake, and then answers the processor. Every processor write is forwarded to memory. The cached copy of the word is also updated if the line is resident, and no line is allocated on a write miss.

A DMA agent can write memory without going through the cache. It reports each such write on a snoop input. A snoop write that falls in a resident block clears that line's valid bit, so the next access to the block fetches fresh data.

Top module: `wtCache`

## Requirements
- R1: The word address is divided as tag = bits 15:11, line index = bits 10:4 and word offset = bits 3:0. An access hits only when the indexed line is valid and its stored tag equals the address tag.
- R2: After reset every line is invalid, so the first read of any address is a miss. During reset `cpuReady`, `memRd` and `memWr` are low.
- R3: A read miss issues exactly 16 memory reads. Their addresses are {tag, index, offset} with the offset running 0 to 15 in order. `cpuReady` rises only after the last word is acknowledged, and `cpuRdata` then holds the word at the requested offset.
- R4: A read hit asserts `cpuReady` in the cycle after the request is accepted and issues no memory read. `cpuReady` is always a single-cycle pulse.
- R5: Every processor write produces exactly one memory write carrying the processor's address and data. `cpuReady` follows in the cycle after the acknowledge.
- R6: A write that hits also updates the cached word, so a later read hit returns the new data.
- R7: A write miss allocates no line, so a later read of that address misses and returns the written data from memory.
- R8: A snoop write whose block is resident clears that line's valid bit, so the next read of the block misses and returns the DMA data.
- R9: A snoop write to a block that is not resident (same index with a different tag, or a different index) leaves the resident lines valid.
- R10: If a snoop invalidation and a processor access target the same resident block in the same cycle, the invalidation wins and the access is handled as a miss.
- R11: Blocks whose addresses differ only in the tag share one line, so loading one of them evicts the other.
- R12: `memRd` and `memWr` are never high together, and a memory request stays asserted until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | Processor word address, held until cpuReady |
| cpuRd | input | 1 | Processor read strobe, held until cpuReady |
| cpuWr | input | 1 | Processor write strobe, held until cpuReady |
| cpuWdata | input | 16 | Processor write data |
| cpuRdata | output | 16 | Read data, meaningful while cpuReady is high for a read |
| cpuReady | output | 1 | One-cycle completion pulse |
| memAddr | output | 16 | Memory word address |
| memRd | output | 1 | Memory read request |
| memWr | output | 1 | Memory write request |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory acknowledge, one cycle per word |
| snoopValid | input | 1 | A DMA write to memory occurred this cycle |
| snoopAddr | input | 16 | Word address of that DMA write |

## Verification
The hardest case to reach is the race in which a snoop invalidation and a processor read land on the same resident line in the same clock cycle. The bench gets there with a driver call that raises the read strobe and a one-cycle snoop pulse on the same edge. It then counts the memory reads that follow, which shows whether the access was handled as a miss. Tag conflicts are reached by alternating two addresses that differ only in bit 11 and above. The snoop cases are built on lines already made resident, with snoop addresses chosen to match or miss the stored tag.

// File: rtl/cachePkg.sv
package cachePkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int OFF_W  = 4;
  localparam int IDX_W  = 7;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINES  = 1 << IDX_W;
  localparam int WORDS  = LINES << OFF_W;

  typedef struct packed {
    logic clrValid;  // line about to be refilled
    logic setValid;  // last fill word arrives
    logic fillWe;    // store a fill word
    logic cpuWe;     // store a processor write word (hit)
  } ctlStrobes_t;
endpackage

// File: rtl/cacheDatapath.sv
module cacheDatapath
  import cachePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              hit,
  input  ctlStrobes_t       strobe,
  input  logic [OFF_W-1:0]  fillCnt,
  input  logic              fillPhase,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr
);
  logic [LINES-1:0]  validArr;
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [WORDS];

  logic [TAG_W-1:0] tag, sTag;
  logic [IDX_W-1:0] idx, sIdx;
  logic [OFF_W-1:0] off;
  logic snoopResident, snoopSameBlock;

  assign tag  = cpuAddr[ADDR_W-1 -: TAG_W];
  assign idx  = cpuAddr[OFF_W +: IDX_W];
  assign off  = cpuAddr[OFF_W-1:0];
  assign sTag = snoopAddr[ADDR_W-1 -: TAG_W];
  assign sIdx = snoopAddr[OFF_W +: IDX_W];

  assign snoopResident  = snoopValid && validArr[sIdx] && (tagArr[sIdx] == sTag);
  assign snoopSameBlock = snoopValid && (snoopAddr[ADDR_W-1:OFF_W] == cpuAddr[ADDR_W-1:OFF_W]);

  always_comb begin
    hit = validArr[idx] && (tagArr[idx] == tag);
    if (snoopResident && (sIdx == idx)) hit = 1'b0;
  end

  assign memAddr  = fillPhase ? {tag, idx, fillCnt} : cpuAddr;
  assign memWdata = cpuWdata;
  assign cpuRdata = dataArr[{idx, off}];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validArr <= '0;
    end else begin
      if (snoopResident)   validArr[sIdx] <= 1'b0;
      if (strobe.clrValid) validArr[idx]  <= 1'b0;
      if (strobe.setValid) validArr[idx]  <= !snoopSameBlock;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.setValid) tagArr[idx] <= tag;
    if (strobe.fillWe)   dataArr[{idx, fillCnt}] <= memRdata;
    else if (strobe.cpuWe) dataArr[{idx, off}] <= cpuWdata;
  end

  // R8: a resident block named by the snoop is invalid one cycle later
  a_r8_snoop_clears: assert property (@(posedge clk) disable iff (!rstN)
    (snoopResident && !(strobe.setValid && sIdx == idx)) |=> !validArr[$past(sIdx)]);
  // R10: same-cycle invalidation of the accessed line masks the hit
  a_r10_snoop_wins: assert property (@(posedge clk) disable iff (!rstN)
    (snoopResident && sIdx == idx) |-> !hit);
endmodule

// File: rtl/cacheControl.sv
module cacheControl
  import cachePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuRd,
  input  logic             cpuWr,
  input  logic             hit,
  input  logic             memAck,
  output ctlStrobes_t      strobe,
  output logic [OFF_W-1:0] fillCnt,
  output logic             memRd,
  output logic             memWr,
  output logic             cpuReady
);
  typedef enum logic [1:0] {S_IDLE, S_FILL, S_WRITE, S_DONE} state_t;
  state_t state, stateNext;
  logic lastWord;

  assign lastWord = (fillCnt == {OFF_W{1'b1}});
  assign memRd    = (state == S_FILL);
  assign memWr    = (state == S_WRITE);
  assign cpuReady = (state == S_DONE);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      S_IDLE: begin
        if (cpuWr) begin
          strobe.cpuWe = hit;
          stateNext    = S_WRITE;
        end else if (cpuRd) begin
          if (hit) begin
            stateNext = S_DONE;
          end else begin
            strobe.clrValid = 1'b1;
            stateNext       = S_FILL;
          end
        end
      end
      S_FILL: begin
        if (memAck) begin
          strobe.fillWe = 1'b1;
          if (lastWord) begin
            strobe.setValid = 1'b1;
            stateNext       = S_DONE;
          end
        end
      end
      S_WRITE: if (memAck) stateNext = S_DONE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      fillCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE)          fillCnt <= '0;
      else if (memRd && memAck)     fillCnt <= fillCnt + 1'b1;
    end
  end

  // R12: never both memory requests, and a request waits for its acknowledge
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rstN) !(memRd && memWr));
  a_r12_hold_rd: assert property (@(posedge clk) disable iff (!rstN) (memRd && !memAck) |=> memRd);
  a_r12_hold_wr: assert property (@(posedge clk) disable iff (!rstN) (memWr && !memAck) |=> memWr);
  // R4: completion is a single-cycle pulse
  a_r4_pulse: assert property (@(posedge clk) disable iff (!rstN) cpuReady |=> !cpuReady);
  // R5: memory writes only come from processor writes
  a_r5_write_origin: assert property (@(posedge clk) disable iff (!rstN) memWr |-> cpuWr);
  // R3: the last acknowledged fill word is followed by completion
  a_r3_fill_done: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && memAck && lastWord) |=> cpuReady);
endmodule

// File: rtl/wtCache.sv
module wtCache
  import cachePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr
);
  ctlStrobes_t      strobe;
  logic [OFF_W-1:0] fillCnt;
  logic             hit;

  cacheControl u_ctl (
    .clk(clk), .rstN(rstN), .cpuRd(cpuRd), .cpuWr(cpuWr), .hit(hit),
    .memAck(memAck), .strobe(strobe), .fillCnt(fillCnt),
    .memRd(memRd), .memWr(memWr), .cpuReady(cpuReady)
  );

  cacheDatapath u_dp (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .hit(hit), .strobe(strobe), .fillCnt(fillCnt),
    .fillPhase(memRd), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .snoopValid(snoopValid), .snoopAddr(snoopAddr)
  );
endmodule

// File: tb/sim_wtCache.sv
module sim_wtCache;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0, cpuWdata = '0, memRdata = '0, snoopAddr = '0;
  logic        cpuRd = 1'b0, cpuWr = 1'b0, memAck = 1'b0, snoopValid = 1'b0;
  logic [15:0] cpuRdata, memAddr, memWdata;
  logic        cpuReady, memRd, memWr;

  always #2.5 clk = ~clk;  // 200 MHz

  wtCache u0 (.*);

  int nChecks = 0, nFail = 0;
  int rdAcks = 0, wrAcks = 0, lat = 0;
  bit finished = 0;
  logic [15:0] memWrites [int];
  logic [15:0] lastFillAddr = '0;
  logic [16:0] sbq [$];

  function automatic logic [15:0] memVal(input logic [15:0] a);
    if (memWrites.exists(int'(a))) return memWrites[int'(a)];
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: acknowledge after two waiting cycles
  always @(negedge clk) begin
    if (memAck) memAck = 1'b0;
    else if (memRd || memWr) begin
      if (memRd && memWr) chk(0, "R12 both requests", 1, 0);
      if (lat == 1) begin
        lat = 0;
        memAck = 1'b1;
        if (memWr) begin
          memWrites[int'(memAddr)] = memWdata;
          wrAcks++;
        end else begin
          memRdata = memVal(memAddr);
          if (memAddr[3:0] != 4'd0)
            chk(memAddr == lastFillAddr + 16'd1, "R3 fill order", memAddr, lastFillAddr + 16'd1);
          lastFillAddr = memAddr;
          rdAcks++;
        end
      end else lat++;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && cpuReady) begin
      if (sbq.size() == 0) chk(0, "R4 unexpected ready", 1, 0);
      else begin
        logic [16:0] item;
        item = sbq.pop_front();
        if (item[16]) chk(cpuRdata == item[15:0], "R3/R6 read data", cpuRdata, item[15:0]);
      end
    end
  end

  task automatic snoopWrite(input logic [15:0] a, input logic [15:0] d);
    memWrites[int'(a)] = d;
    @(posedge clk); #1;
    snoopValid = 1'b1; snoopAddr = a;
    @(posedge clk); #1;
    snoopValid = 1'b0;
  endtask

  task automatic access(input bit isWr, input logic [15:0] a, input logic [15:0] d,
                        input int expFetch, input string req,
                        input bit withSnoop, input logic [15:0] sA);
    int r0, w0;
    r0 = rdAcks; w0 = wrAcks;
    if (withSnoop) memWrites[int'(sA)] = 16'hC0DE;
    sbq.push_back({!isWr, isWr ? 16'h0 : memVal(a)});
    @(posedge clk); #1;
    cpuAddr = a; cpuWdata = d; cpuRd = !isWr; cpuWr = isWr;
    if (withSnoop) begin
      snoopValid = 1'b1; snoopAddr = sA;
      fork begin @(posedge clk); #1; snoopValid = 1'b0; end join_none
    end
    do @(negedge clk); while (!cpuReady);
    chk(rdAcks - r0 == expFetch, req, rdAcks - r0, expFetch);
    if (isWr) chk(wrAcks - w0 == 1, "R5 one memory write", wrAcks - w0, 1);
    @(posedge clk); #1;
    cpuRd = 1'b0; cpuWr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!cpuReady && !memRd && !memWr, "R2 reset outputs", {cpuReady, memRd, memWr}, 0);
    @(posedge clk); #1 rstN = 1'b1;

    access(0, 16'h1234, 0, 16, "R2 R3 first read misses", 0, 0);
    access(0, 16'h1235, 0, 0, "R4 R1 hit no traffic", 0, 0);
    access(0, 16'h123F, 0, 0, "R4 hit last offset", 0, 0);
    access(1, 16'h1236, 16'hBEEF, 0, "R5 write hit", 0, 0);
    access(0, 16'h1236, 0, 0, "R6 read after write hit", 0, 0);
    access(1, 16'h4000, 16'h1111, 0, "R5 write miss", 0, 0);
    access(0, 16'h4000, 0, 16, "R7 no allocate on write miss", 0, 0);
    access(0, 16'h1A34, 0, 16, "R11 conflicting tag misses", 0, 0);
    access(0, 16'h1234, 0, 16, "R11 evicted block refetched", 0, 0);
    snoopWrite(16'h1230, 16'h7777);
    access(0, 16'h1230, 0, 16, "R8 snoop invalidates", 0, 0);
    snoopWrite(16'h1A30, 16'h2222);
    snoopWrite(16'h0230, 16'h3333);
    access(0, 16'h1231, 0, 0, "R9 unrelated snoop keeps line", 0, 0);
    access(0, 16'h4005, 0, 0, "R9 other line still valid", 0, 0);
    access(0, 16'h1232, 0, 16, "R10 same-cycle snoop wins", 1, 16'h123A);
    access(0, 16'h123A, 0, 0, "R10 refilled line holds DMA data", 0, 0);
    access(1, 16'h9999, 16'h4444, 0, "R5 write miss other line", 0, 0);
    access(0, 16'h9999, 0, 16, "R7 written data from memory", 0, 0);

    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R4 all completions seen", sbq.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule